// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a free-running watchdog timer clocked from a 32.768 kHz low-speed clock. Once reset is released it counts without pause. Software cannot disable it. Each time the count reaches the selected period, an overflow occurs.

The first overflow that software has not serviced raises a non-maskable interrupt request. This gives firmware a last chance to recover. If the period elapses a second time without a valid clear, the block drops the interrupt and drives a reset request for a fixed number of clock cycles. The block then returns itself to its power-up state.

Software services the timer through a small write-only register interface with two addresses:
- **Clear register.** Software writes a two-byte key to it.
- **Period register.** It selects one of four periods and accepts only the first write after each reset.

Top module: `wdt_escalate`

## Requirements
- R1: The counter runs from reset release without any enable. With the period register at its reset value 0, `nmi_req` rises exactly 2^BASE_LOG2 clock edges after `rst_n` is released.
- R2: The period register value s (bits [1:0]) selects an overflow period of 2^(BASE_LOG2 + 2*s) cycles. With the default BASE_LOG2 = 12, the four periods are 4096, 16384, 65536 and 262144 cycles, which is 125 ms, 500 ms, 2 s and 8 s at 32.768 kHz.
- R3: The first overflow sets `nmi_req`. It stays high until a valid clear or until escalation to reset.
- R4: A second overflow while `nmi_req` is high raises `rst_req` for exactly RST_HOLD cycles (default 4).
- R5: When the reset hold ends, the block returns to its power-up state: counter 0, no NMI pending, period value 0, and the period register writable again.
- R6: A valid clear consists of two writes to the clear register (wr_addr = 0):
  - first, data 0x5A;
  - then, as the very next clear-register write, data 0xA5.

  On the edge that takes the 0xA5, the counter and the NMI stage are zeroed. `nmi_req` is low after that edge.
- R7: Any other sequence of clear-register writes leaves the counter running and `nmi_req` unchanged. This includes 0xA5 without a preceding 0x5A, and a different value between 0x5A and 0xA5.
- R8: The period register (wr_addr = 1) takes only the first write after a reset. Later writes are ignored.
- R9: `nmi_req` and `rst_req` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Low-speed counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 1 | 0 = clear register, 1 = period register |
| wr_data | input | 8 | Write data |
| nmi_req | output | 1 | Non-maskable interrupt request, first stage |
| rst_req | output | 1 | System reset request, second stage |

## Verification
The assertions assume that `wr_en` is a clean single-cycle strobe per write and that `wr_addr` and `wr_data` are valid whenever it is high. They also assume `rst_n` is the only external reset and is not pulsed while a reset hold is running. The bench drives every write as a one-cycle strobe set up at the falling edge, so each write is taken by exactly one rising edge. It never touches `rst_n` in the middle of a scenario. The bench reduces BASE_LOG2 to 4 so that all four periods and the full escalation path fit in a short run, while the period encoding stays the same.

// File: rtl/wdt_escalate.sv
`timescale 1ns/1ps
module wdt_escalate #(
  parameter int BASE_LOG2 = 12,
  parameter int RST_HOLD  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output logic       nmi_req,
  output logic       rst_req
);
  localparam int CW = BASE_LOG2 + 7;
  localparam int HW = $clog2(RST_HOLD + 1);
  localparam logic [7:0] KEY_ARM  = 8'h5A;
  localparam logic [7:0] KEY_FIRE = 8'hA5;

  logic [CW-1:0] cnt, limit;
  logic [1:0]    per_sel;
  logic          locked, stage, armed;
  logic [HW-1:0] hcnt;

  wire holding  = (hcnt != '0);
  wire hold_end = (hcnt == HW'(1));
  wire clr_wr   = wr_en && !wr_addr && !holding;
  wire per_wr   = wr_en && wr_addr && !holding && !locked;
  wire key_ok   = clr_wr && armed && (wr_data == KEY_FIRE);

  assign limit   = CW'(1) << (BASE_LOG2 + 2 * int'(per_sel));
  wire   ovf     = !holding && (cnt >= limit - CW'(1));

  assign nmi_req = stage;
  assign rst_req = holding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; per_sel <= '0; locked <= 1'b0;
      stage <= 1'b0; armed <= 1'b0; hcnt <= '0;
    end else if (hold_end) begin
      cnt <= '0; per_sel <= '0; locked <= 1'b0;
      stage <= 1'b0; armed <= 1'b0; hcnt <= '0;
    end else if (holding) begin
      hcnt <= hcnt - HW'(1);
    end else begin
      if (clr_wr) armed <= (wr_data == KEY_ARM);
      if (per_wr) begin
        per_sel <= wr_data[1:0];
        locked  <= 1'b1;
      end
      if (key_ok) begin
        cnt   <= '0;
        stage <= 1'b0;
      end else if (ovf) begin
        cnt <= '0;
        if (stage) begin
          stage <= 1'b0;
          armed <= 1'b0;
          hcnt  <= HW'(RST_HOLD);
        end else begin
          stage <= 1'b1;
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_escalate_chk.sv
`timescale 1ns/1ps
module wdt_escalate_chk #(
  parameter int RST_HOLD = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_addr,
  input logic [7:0] wr_data,
  input logic       nmi_req,
  input logic       rst_req,
  input logic       armed,
  input logic       locked,
  input logic [1:0] per_sel,
  input logic       hold_end
);
  logic [15:0] hc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hc <= '0;
    else        hc <= rst_req ? hc + 16'd1 : 16'd0;
  end

  // R9
  nmi_rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !nmi_req);

  // R4
  escalate_from_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(nmi_req));

  // R4
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> hc == 16'(RST_HOLD));

  // R4
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> hc < 16'(RST_HOLD));

  // R6
  key_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && wr_data == 8'hA5 && armed && !rst_req) |=> (!nmi_req && !rst_req));

  // R8
  period_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !hold_end) |=> $stable(per_sel));
endmodule

bind wdt_escalate wdt_escalate_chk #(.RST_HOLD(RST_HOLD)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .nmi_req(nmi_req), .rst_req(rst_req), .armed(armed), .locked(locked),
  .per_sel(per_sel), .hold_end(hold_end)
);

// File: tb/wdt_escalate_tb.sv
`timescale 1ns/1ps
module wdt_escalate_tb_top;
  localparam int B = 4;
  localparam int L0 = 1 << B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic nmi_req, rst_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  wdt_escalate #(.BASE_LOG2(B), .RST_HOLD(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .nmi_req(nmi_req), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset nmi", nmi_req, 1'b0);
    chk("R1 reset rst", rst_req, 1'b0);
  endtask

  task automatic t_first_and_escalate();
    do_reset();
    wt(L0 - 1); chk("R1 no nmi before period", nmi_req, 1'b0);
    wt(1);      chk("R3 nmi at first overflow", nmi_req, 1'b1);
    wt(5);      chk("R3 nmi held", nmi_req, 1'b1);
    wt(L0 - 6); chk("R4 no rst before second overflow", rst_req, 1'b0);
    wt(1);      chk("R4 rst at second overflow", rst_req, 1'b1);
    chk("R9 nmi low during rst", nmi_req, 1'b0);
    wt(3);      chk("R4 rst held 4th cycle", rst_req, 1'b1);
    wt(1);      chk("R4 rst released", rst_req, 1'b0);
    wt(L0 - 1); chk("R5 restart no early nmi", nmi_req, 1'b0);
    wt(1);      chk("R5 restart nmi after period", nmi_req, 1'b1);
  endtask

  task automatic t_restore_default();
    do_reset();
    wr(1'b1, 8'h01);
    wt(2 * 64 + 4 + L0 - 2); chk("R5 default period restored (before)", nmi_req, 1'b0);
    wt(1);                   chk("R5 default period restored", nmi_req, 1'b1);
    wr(1'b1, 8'h02);
    wt(256 - 2); chk("R5 lock released, no rst yet", rst_req, 1'b0);
    wt(1);       chk("R5 lock released, new period used", rst_req, 1'b1);
    wt(4);
  endtask

  task automatic t_clear();
    do_reset();
    wt(10);
    wr(1'b0, 8'h5A);
    wr(1'b0, 8'hA5);
    wt(L0 - 1); chk("R6 clear restarts count", nmi_req, 1'b0);
    wt(1);      chk("R6 nmi after cleared period", nmi_req, 1'b1);
    wr(1'b0, 8'h5A);
    wr(1'b0, 8'hA5);
    chk("R6 clear drops nmi", nmi_req, 1'b0);
    chk("R6 clear no rst", rst_req, 1'b0);
    wt(L0 - 1); chk("R6 count from zero after clear", nmi_req, 1'b0);
    wt(1);      chk("R6 nmi again after clear", nmi_req, 1'b1);
  endtask

  task automatic t_bad_keys();
    do_reset();
    wr(1'b0, 8'hA5);
    wr(1'b0, 8'h5A);
    wr(1'b0, 8'h33);
    wr(1'b0, 8'hA5);
    wr(1'b0, 8'h5A);
    wr(1'b0, 8'h00);
    wr(1'b0, 8'hA5);
    wt(L0 - 8); chk("R7 bad keys before period", nmi_req, 1'b0);
    wt(1);      chk("R7 bad keys did not clear", nmi_req, 1'b1);
    wr(1'b0, 8'hA5);
    chk("R7 unarmed A5 keeps nmi", nmi_req, 1'b1);
  endtask

  task automatic t_periods();
    for (int s = 0; s < 4; s++) begin
      int len;
      len = 1 << (B + 2 * s);
      do_reset();
      wr(1'b1, 8'(s));
      wt(len - 2); chk($sformatf("R2 period %0d before", s), nmi_req, 1'b0);
      wt(1);       chk($sformatf("R2 period %0d overflow", s), nmi_req, 1'b1);
    end
  endtask

  task automatic t_lock();
    do_reset();
    wr(1'b1, 8'h02);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h03);
    wt(256 - 4); chk("R8 second write ignored (before)", nmi_req, 1'b0);
    wt(1);       chk("R8 first value kept", nmi_req, 1'b1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first_and_escalate();
    t_restore_default();
    t_clear();
    t_bad_keys();
    t_periods();
    t_lock();
    summary();
    $finish;
  end
endmodule